// File: doc/BRIEF.md
# Pulse-Mode Conversion Sequencer

This block runs a sampled flash converter in intermittent, on-demand mode from a faster system clock. A conversion result only moves to the converter's outputs after two converter-clock edges of the same polarity, so each request makes a double pulse. The converter clock goes high for a sample interval, low for a balance interval, and high again for a second sample interval. Its falling edge is the one that delivers the result. The sequencer then keeps the converter in balance and raises a one-cycle `data_valid` once the converter's data-valid time has passed.

Between requests the converter clock is parked low, in the balance phase. Balance may last indefinitely, but a sample held too long lets the balance capacitors droop. The interval lengths come in as system-clock counts. On every launch they are clamped into the legal window, which the block derives from nanosecond limits and the system-clock period: sample at least 25 ns and at most 500 ns, balance at least 33 ns, data-valid wait at least 65 ns. A sticky flag reports any request that had to be clamped. A request that arrives while a conversion is running is held and served as soon as that conversion has finished.

Top module: `pulse_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `conv_clk`, `data_valid` and `timing_err` are all low.
- R2: Suppose `start` is sampled high at a clock edge while the block is idle. Then `conv_clk` is high for S cycles starting with that edge, low for B cycles, high for S cycles again, and then low. S and B are the clamped sample and balance lengths.
- R3: The sample length S is `samp_cycles` clamped into [4, 62]. With the default 8000 ps period, these are ceil(25 ns) and floor(500 ns) in cycles.
- R4: The balance length B is `bal_cycles` raised to at least 5 cycles, which is ceil(33 ns).
- R5: `data_valid` is high for exactly one cycle, D cycles after the edge that ends the second sample. D is `dv_cycles` raised to at least 9 cycles, which is ceil(65 ns).
- R6: With no request pending, `conv_clk` stays low for as long as the block is idle.
- R7: After the second sample ends, `conv_clk` stays low for max(B, D+1) cycles before the next conversion can start.
- R8: A `start` sampled during a conversion is held. The next conversion starts at the edge that ends the current one. Any number of such requests during one conversion produce a single further conversion.
- R9: `timing_err` rises after a launch edge at which any raw length lay outside its window. It stays high until reset.
- R10: The lengths are captured at the launch edge. Changing the length inputs during a conversion does not affect that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Conversion request, sampled on each rising edge |
| samp_cycles | input | LEN_W | Requested sample interval in system-clock cycles |
| bal_cycles | input | LEN_W | Requested balance interval in system-clock cycles |
| dv_cycles | input | LEN_W | Requested wait from the final falling edge to data_valid |
| conv_clk | output | 1 | Converter clock: high = sample, low = balance |
| data_valid | output | 1 | One-cycle pulse when the converter result is stable |
| timing_err | output | 1 | Sticky flag: a request needed clamping |

## Verification
`conv_clk` rises in the cycle that follows the edge at which `start` is sampled. Its later transitions come at S, S+B and 2S+B cycles after that edge. `data_valid` follows 2S+B+D cycles after the launch edge, and `timing_err` changes in the cycle right after the launch. The bench keeps a per-launch time index in its reference model and drives stimulus on falling edges. It compares all three outputs on each falling edge, half a cycle after the rising edge that produced them. Directed checks measure the run lengths of high and low pulses, and the gaps before each rise, which confirm the clamps, the tail length and the merging of pending requests.

// File: rtl/pulse_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared state type and cycle-limit arithmetic for the
// pulse-mode conversion sequencer.
package pulse_seq_pkg;

    // Sequencer phases; converter clock is high only in the two sample phases.
    typedef enum logic [2:0] {
        SEQ_IDLE     = 3'd0,
        SEQ_SAMPLE_A = 3'd1,
        SEQ_BAL_A    = 3'd2,
        SEQ_SAMPLE_B = 3'd3,
        SEQ_TAIL     = 3'd4
    } seq_state_t;

    // Smallest whole number of cycles covering a duration (minimum limits).
    function automatic int cycles_ceil(input int dur_ps, input int period_ps);
        return (dur_ps + period_ps - 1) / period_ps;
    endfunction

    // Largest whole number of cycles fitting inside a duration (maximum limits).
    function automatic int cycles_floor(input int dur_ps, input int period_ps);
        return dur_ps / period_ps;
    endfunction

endpackage

// File: rtl/pulse_seq_cfg.sv
`timescale 1ns/1ps
// Module: pulse_seq_cfg
// Captures the three interval lengths at each launch, clamped into the
// legal windows, and keeps a sticky flag when any raw value was illegal.
// Assumes the cycle limits fit in LEN_W bits and MIN <= MAX for sample.
module pulse_seq_cfg #(
    parameter int LEN_W    = 8,
    parameter int SAMP_MIN = 4,
    parameter int SAMP_MAX = 62,
    parameter int BAL_MIN  = 5,
    parameter int DV_MIN   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [LEN_W-1:0] raw_samp,
    input  logic [LEN_W-1:0] raw_bal,
    input  logic [LEN_W-1:0] raw_dv,
    output logic [LEN_W-1:0] samp_len,
    output logic [LEN_W-1:0] bal_len,
    output logic [LEN_W-1:0] dv_len,
    output logic             timing_err
);

    localparam logic [LEN_W-1:0] SMIN_V = LEN_W'(SAMP_MIN);
    localparam logic [LEN_W-1:0] SMAX_V = LEN_W'(SAMP_MAX);
    localparam logic [LEN_W-1:0] BMIN_V = LEN_W'(BAL_MIN);
    localparam logic [LEN_W-1:0] DMIN_V = LEN_W'(DV_MIN);

    logic [LEN_W-1:0] samp_fix, bal_fix, dv_fix;
    logic             samp_low, samp_high, bal_low, dv_low;

    // Range tests on the raw request values.
    always_comb begin
        samp_low  = raw_samp < SMIN_V;
        samp_high = raw_samp > SMAX_V;
        bal_low   = raw_bal  < BMIN_V;
        dv_low    = raw_dv   < DMIN_V;
    end

    // Clamp each request into its legal window.
    always_comb begin
        samp_fix = samp_low ? SMIN_V : (samp_high ? SMAX_V : raw_samp);
        bal_fix  = bal_low  ? BMIN_V : raw_bal;
        dv_fix   = dv_low   ? DMIN_V : raw_dv;
    end

    // Hold the clamped lengths for the conversion that is launching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_len <= SMIN_V;
            bal_len  <= BMIN_V;
            dv_len   <= DMIN_V;
        end else if (launch) begin
            samp_len <= samp_fix;
            bal_len  <= bal_fix;
            dv_len   <= dv_fix;
        end
    end

    // Sticky violation flag, set at a launch that needed clamping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timing_err <= 1'b0;
        end else if (launch && (samp_low || samp_high || bal_low || dv_low)) begin
            timing_err <= 1'b1;
        end
    end

endmodule

// File: rtl/pulse_seq_req.sv
`timescale 1ns/1ps
// Module: pulse_seq_req
// Holds one start request that arrives while a conversion is running and
// presents it, merged with a live start, as the request to launch.
// Assumes busy is low only when the sequencer is idle.
module pulse_seq_req (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic busy,
    input  logic launch,
    output logic want
);

    logic pend_q;

    // Remember a start seen while busy; drop it when a conversion launches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (launch) begin
            pend_q <= 1'b0;
        end else if (start && busy) begin
            pend_q <= 1'b1;
        end
    end

    // A launch is wanted for a live request or a held one.
    always_comb begin
        want = start || pend_q;
    end

endmodule

// File: rtl/pulse_seq_ctrl.sv
`timescale 1ns/1ps
// Module: pulse_seq_ctrl
// Phase machine: sample, balance, sample, then a balance tail that covers
// both the minimum balance and the data-valid wait. The converter clock is
// a registered output; data_valid is decoded from state and counter flops.
// Assumes the lengths are stable except at a launch edge.
module pulse_seq_ctrl
    import pulse_seq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             want,
    input  logic [LEN_W-1:0] samp_len,
    input  logic [LEN_W-1:0] bal_len,
    input  logic [LEN_W-1:0] dv_len,
    output logic             launch,
    output logic             busy,
    output logic             conv_clk,
    output logic             data_valid
);

    localparam int CNT_W = LEN_W + 1;

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] samp_w, bal_w, dv_w, dv_plus, tail_need;

    // Widen the lengths to the counter width.
    always_comb begin
        samp_w    = {1'b0, samp_len};
        bal_w     = {1'b0, bal_len};
        dv_w      = {1'b0, dv_len};
        dv_plus   = dv_w + CNT_W'(1);
        tail_need = (bal_w > dv_plus) ? bal_w : dv_plus;
    end

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:     if (want)              state_d = SEQ_SAMPLE_A;
            SEQ_SAMPLE_A: if (cnt_q == samp_w)   state_d = SEQ_BAL_A;
            SEQ_BAL_A:    if (cnt_q == bal_w)    state_d = SEQ_SAMPLE_B;
            SEQ_SAMPLE_B: if (cnt_q == samp_w)   state_d = SEQ_TAIL;
            SEQ_TAIL:     if (cnt_q >= tail_need) state_d = want ? SEQ_SAMPLE_A : SEQ_IDLE;
            default:                             state_d = SEQ_IDLE;
        endcase
    end

    // Launch marks entry into the first sample from idle or tail.
    always_comb begin
        launch = (state_d == SEQ_SAMPLE_A) && (state_q != SEQ_SAMPLE_A);
        busy   = (state_q != SEQ_IDLE);
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Cycles spent in the current phase, counting from one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_d == SEQ_IDLE) begin
            cnt_q <= '0;
        end else if (state_d != state_q) begin
            cnt_q <= CNT_W'(1);
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Glitch-free converter clock: high in the two sample phases.
    always_ff @(posedge clk) begin
        if (!rst_n) conv_clk <= 1'b0;
        else        conv_clk <= (state_d == SEQ_SAMPLE_A) || (state_d == SEQ_SAMPLE_B);
    end

    // Result strobe, dv_len cycles after the closing falling edge.
    always_comb begin
        data_valid = (state_q == SEQ_TAIL) && (cnt_q == dv_plus);
    end

endmodule

// File: rtl/pulse_seq.sv
`timescale 1ns/1ps
// Module: pulse_seq (top)
// Pulse-mode sequencer for a two-edge flash converter: double-pulses the
// converter clock per request, parks it in balance while idle, clamps the
// phase lengths to limits derived from nanosecond bounds and the system
// clock period, and strobes data_valid when the result is stable.
// Assumes start and the length inputs are synchronous to clk.
module pulse_seq
    import pulse_seq_pkg::*;
#(
    parameter int LEN_W       = 8,
    parameter int CLK_PS      = 8000,
    parameter int SAMP_MIN_PS = 25000,
    parameter int SAMP_MAX_PS = 500000,
    parameter int BAL_MIN_PS  = 33000,
    parameter int DV_WAIT_PS  = 65000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] samp_cycles,
    input  logic [LEN_W-1:0] bal_cycles,
    input  logic [LEN_W-1:0] dv_cycles,
    output logic             conv_clk,
    output logic             data_valid,
    output logic             timing_err
);

    localparam int SAMP_MIN_CYC = cycles_ceil(SAMP_MIN_PS, CLK_PS);
    localparam int SAMP_MAX_CYC = cycles_floor(SAMP_MAX_PS, CLK_PS);
    localparam int BAL_MIN_CYC  = cycles_ceil(BAL_MIN_PS, CLK_PS);
    localparam int DV_MIN_CYC   = cycles_ceil(DV_WAIT_PS, CLK_PS);

    logic             launch, busy, want;
    logic [LEN_W-1:0] samp_len, bal_len, dv_len;

    pulse_seq_req u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .busy   (busy),
        .launch (launch),
        .want   (want)
    );

    pulse_seq_cfg #(
        .LEN_W    (LEN_W),
        .SAMP_MIN (SAMP_MIN_CYC),
        .SAMP_MAX (SAMP_MAX_CYC),
        .BAL_MIN  (BAL_MIN_CYC),
        .DV_MIN   (DV_MIN_CYC)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .raw_samp   (samp_cycles),
        .raw_bal    (bal_cycles),
        .raw_dv     (dv_cycles),
        .samp_len   (samp_len),
        .bal_len    (bal_len),
        .dv_len     (dv_len),
        .timing_err (timing_err)
    );

    pulse_seq_ctrl #(
        .LEN_W (LEN_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .want       (want),
        .samp_len   (samp_len),
        .bal_len    (bal_len),
        .dv_len     (dv_len),
        .launch     (launch),
        .busy       (busy),
        .conv_clk   (conv_clk),
        .data_valid (data_valid)
    );

endmodule

// File: rtl/pulse_seq_chk.sv
`timescale 1ns/1ps
// Module: pulse_seq_chk
// Port-level protocol checker: measures converter-clock run lengths with
// its own counters and checks them against the cycle limits.
module pulse_seq_chk #(
    parameter int LEN_W    = 8,
    parameter int SAMP_MIN = 4,
    parameter int SAMP_MAX = 62,
    parameter int BAL_MIN  = 5
) (
    input logic clk,
    input logic rst_n,
    input logic conv_clk,
    input logic data_valid,
    input logic timing_err
);

    localparam int RUN_W = LEN_W + 2;
    localparam logic [RUN_W-1:0] RUN_TOP = '1;

    logic [RUN_W-1:0] hi_run, lo_run;
    logic             armed;

    // Length of the current high run and low run of conv_clk, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= conv_clk ? ((hi_run == RUN_TOP) ? hi_run : hi_run + 1'b1) : '0;
            lo_run <= conv_clk ? '0 : ((lo_run == RUN_TOP) ? lo_run : lo_run + 1'b1);
        end
    end

    // Armed once a sample has ended, so the idle run after reset is exempt.
    always_ff @(posedge clk) begin
        if (!rst_n)                      armed <= 1'b0;
        else if (!conv_clk && hi_run != '0) armed <= 1'b1;
    end

    assert_sample_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_clk |-> (hi_run < RUN_W'(SAMP_MAX)));

    assert_sample_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_clk) |-> (hi_run >= RUN_W'(SAMP_MIN)));

    assert_balance_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(conv_clk) && armed) |-> (lo_run >= RUN_W'(BAL_MIN)));

    assert_dv_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);

    assert_dv_in_balance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> !conv_clk);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        timing_err |=> timing_err);

endmodule

bind pulse_seq pulse_seq_chk #(
    .LEN_W    (LEN_W),
    .SAMP_MIN (SAMP_MIN_CYC),
    .SAMP_MAX (SAMP_MAX_CYC),
    .BAL_MIN  (BAL_MIN_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_clk   (conv_clk),
    .data_valid (data_valid),
    .timing_err (timing_err)
);

// File: tb/pulse_seq_test.sv
`timescale 1ns/1ps
module pulse_seq_test;

    localparam int SMIN = 4, SMAX = 62, BMIN = 5, DMIN = 9;

    logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [7:0] s_raw = 8'd6, b_raw = 8'd8, d_raw = 8'd10;
    logic       conv_clk, data_valid, timing_err;

    always #4 clk = ~clk;

    pulse_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .samp_cycles(s_raw), .bal_cycles(b_raw), .dv_cycles(d_raw),
        .conv_clk(conv_clk), .data_valid(data_valid), .timing_err(timing_err)
    );

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    // Reference model: time index since launch, held request, sticky error.
    bit m_act = 0, m_pend = 0, m_err = 0;
    int m_t = 0, m_ls = SMIN, m_lb = BMIN, m_dv = DMIN, m_end = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_act = 0; m_pend = 0; m_err = 0; m_t = 0;
        end else begin
            if (m_act) begin
                m_t++;
                if (m_t == m_end) m_act = 0;
            end
            if (!m_act && (start || m_pend)) begin
                m_ls = (s_raw < SMIN) ? SMIN : ((s_raw > SMAX) ? SMAX : int'(s_raw));
                m_lb = (b_raw < BMIN) ? BMIN : int'(b_raw);
                m_dv = (d_raw < DMIN) ? DMIN : int'(d_raw);
                if (s_raw < SMIN || s_raw > SMAX || b_raw < BMIN || d_raw < DMIN) m_err = 1;
                m_end = 2*m_ls + m_lb + ((m_lb > m_dv+1) ? m_lb : m_dv+1);
                m_act = 1; m_t = 0; m_pend = 0;
            end else if (start && m_act) begin
                m_pend = 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Run-length monitor.
    bit prev_cc = 0;
    int run = 0, hi_last = 0, rises = 0, dvs = 0;
    int gaps[$];

    task automatic clear_stats();
        rises = 0; dvs = 0; hi_last = 0; gaps.delete();
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (cyc > 0 && !done) begin
            bit exp_cc, exp_dv;
            exp_cc = m_act && (m_t < m_ls || (m_t >= m_ls + m_lb && m_t < 2*m_ls + m_lb));
            exp_dv = m_act && (m_t == 2*m_ls + m_lb + m_dv);
            chk(m_act ? "R2 conv_clk" : "R6 conv_clk parked", int'(conv_clk), int'(exp_cc));
            chk("R5 data_valid", int'(data_valid), int'(exp_dv));
            chk("R9 timing_err", int'(timing_err), int'(m_err));
            if (conv_clk == prev_cc) run++;
            else begin
                if (prev_cc) hi_last = run;
                else gaps.push_back(run);
                if (conv_clk) rises++;
                run = 1;
            end
            prev_cc = conv_clk;
            if (data_valid) dvs++;
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog.
    always @(negedge clk) begin
        if (cyc > 150000 && !done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            finish_up();
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_act || m_pend);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 conv_clk in reset", int'(conv_clk), 0);
        chk("R1 data_valid in reset", int'(data_valid), 0);
        chk("R1 timing_err in reset", int'(timing_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 timing_err after reset", int'(timing_err), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 conv_clk", int'(conv_clk), 0);
        chk("R1 data_valid", int'(data_valid), 0);
        chk("R1 timing_err", int'(timing_err), 0);
        rst_n = 1'b1;

        // Idle park.
        clear_stats();
        repeat (30) @(negedge clk);
        chk("R6 no pulse while idle", rises, 0);

        // Plain double pulse, legal lengths.
        clear_stats();
        pulse_start(); wait_idle();
        chk("R2 two rises", rises, 2);
        chk("R2 sample width", hi_last, 6);
        chk("R2 balance width", gaps[1], 8);
        chk("R5 one strobe", dvs, 1);
        chk("R9 legal request no error", int'(timing_err), 0);

        // Over-long sample, short balance and wait: clamps and error.
        s_raw = 8'd100; b_raw = 8'd2; d_raw = 8'd3;
        clear_stats();
        pulse_start(); wait_idle();
        chk("R3 sample clamped to max", hi_last, SMAX);
        chk("R4 balance clamped to min", gaps[1], BMIN);
        chk("R5 one strobe clamped wait", dvs, 1);
        chk("R9 error set", int'(timing_err), 1);
        repeat (5) @(negedge clk);
        chk("R9 error sticky", int'(timing_err), 1);
        do_reset();

        // Short sample raised to minimum.
        s_raw = 8'd2; b_raw = 8'd8; d_raw = 8'd10;
        clear_stats();
        pulse_start(); wait_idle();
        chk("R3 sample clamped to min", hi_last, SMIN);
        chk("R9 error on short sample", int'(timing_err), 1);
        do_reset();

        // Requests during a conversion merge into one more conversion.
        s_raw = 8'd5; b_raw = 8'd6; d_raw = 8'd12;
        clear_stats();
        pulse_start();
        repeat (3) @(negedge clk);
        pulse_start();
        repeat (4) @(negedge clk);
        pulse_start();
        wait_idle();
        chk("R8 two conversions four rises", rises, 4);
        chk("R8 two strobes", dvs, 2);
        chk("R7 tail gap before next launch", gaps[2], 13);

        // Length inputs changed mid-conversion have no effect.
        clear_stats();
        pulse_start();
        repeat (2) @(negedge clk);
        s_raw = 8'd30; b_raw = 8'd20; d_raw = 8'd40;
        wait_idle();
        chk("R10 sample kept", hi_last, 5);
        chk("R10 balance kept", gaps[1], 6);

        // Random requests and lengths, compared every cycle with the model.
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (i % 50 == 0) begin
                s_raw = 8'($urandom_range(1, 70));
                b_raw = 8'($urandom_range(1, 20));
                d_raw = 8'($urandom_range(1, 30));
            end
            start = ($urandom_range(0, 9) == 0);
        end
        start = 1'b0;
        wait_idle();
        finish_up();
    end

endmodule